// File: doc/BRIEF.md
# Multiply-Accumulate Tap with Merged Ones-Count Check

This block is one unsigned multiply-accumulate stage of a direct-form filter. It forms `acc_out = acc_in + coef * smp`. The product comes from an array of ripple adders, one per coefficient bit, each adding a shifted copy of the sample. A final ripple adder adds the product to the incoming accumulator. Each data operand travels with a check value, which is the count of set bits in that operand. The block returns the new accumulator together with a predicted check value for it.

The product's own check value is never formed. The block uses one balance equation in its place. On the left side is the coefficient count times the sample count, plus the incoming accumulator count. On the right side are three terms: the ones-count of the new accumulator, the weighted carry count of the accumulator adder, and the sum of the weighted carry counts of every array stage. In each carry count, a stage's carry out of its top bit counts twice and every internal carry counts once. The error flag goes high when the two sides differ.

A unidirectional upset in an operand, or in its check value, makes the two sides unequal and so raises the flag. The data path has no other error check. Outputs are registered: the flag, the sum and the check value all appear one cycle after the inputs. They appear together in the same cycle.

Top module: `berger_mac_tap`

## Requirements
- R1: One clock after the inputs are applied, `acc_out` equals `(acc_in + coef*smp) mod 2^AW`, where AW = 2*DW + clog2(TAPS) (11 with the defaults).
- R2: When `coef_cnt`, `smp_cnt` and `acc_in_cnt` each equal the number of set bits of their operand, `chk_err` is 0 one clock later, for every combination of operand values.
- R3: Whenever `chk_err` is 0, `acc_out_cnt` equals the number of set bits in `acc_out`.
- R4: If `smp_cnt` differs from the set-bit count of `smp` while `coef` is nonzero and the other two counts are correct, `chk_err` is 1 one clock later.
- R5: If `coef_cnt` differs from the set-bit count of `coef` while `smp` is nonzero and the other two counts are correct, `chk_err` is 1 one clock later.
- R6: If `acc_in_cnt` differs from the set-bit count of `acc_in` and the other two counts are correct, `chk_err` is 1 one clock later, whatever the product is.
- R7: When the accumulator sum exceeds 2^AW - 1 it wraps modulo 2^AW. With correct counts, the wrapped result still gives `chk_err` = 0.
- R8: While `rst` is high at a clock edge, `acc_out`, `acc_out_cnt` and `chk_err` are all cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef | input | DW | Unsigned coefficient |
| coef_cnt | input | clog2(DW+1) | Set-bit count supplied with `coef` |
| smp | input | DW | Unsigned sample |
| smp_cnt | input | clog2(DW+1) | Set-bit count supplied with `smp` |
| acc_in | input | AW | Incoming partial sum |
| acc_in_cnt | input | clog2(AW+1) | Set-bit count supplied with `acc_in` |
| acc_out | output | AW | Registered outgoing partial sum |
| acc_out_cnt | output | clog2(AW+1) | Registered predicted set-bit count of `acc_out` |
| chk_err | output | 1 | Registered balance-equation mismatch flag |

## Verification
All 256 coefficient and sample pairs are run against eight partial-sum patterns with correct counts. The patterns include all-zeros, all-ones, alternating bits and top-heavy values, so both the carry-free and the long-carry-chain cases of the balance equation occur, and so does accumulator wrap. The whole pair space is then run again with the sample count raised by one, and once more with the coefficient count raised by one. The flag is expected exactly when the other operand is nonzero. This separates a real detection from a multiply-by-zero product that cannot show the upset. Finally, corrupted partial-sum counts are applied, and a reset is asserted in the middle of a run while the inputs carry faulty counts.

// File: rtl/tap_pkg.sv
package tap_pkg;
  // width of a set-bit count for an n-bit word
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

  // accumulator width for a tap in a chain of `taps` stages
  function automatic int acc_w(input int dw, input int taps);
    return 2 * dw + $clog2(taps);
  endfunction

  // width that holds every count sum of the balance equation without wrap
  function automatic int sum_w(input int dw, input int aw);
    return $clog2(dw * dw + dw * (4 * dw + 2) + 4 * aw + 8) + 1;
  endfunction
endpackage

// File: rtl/tap_ones_count.sv
module tap_ones_count #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(v[i]);
  end
endmodule

// File: rtl/tap_ripple_add.sv
module tap_ripple_add #(
  parameter int W  = 8,
  parameter int CW = 6
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  sum,
  output logic [CW-1:0] ccnt
);
  logic [W:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  // carry out of the top bit weighs two, internal carries weigh one
  always_comb begin
    ccnt = CW'(2) * CW'(cy[W]);
    for (int i = 1; i < W; i++) ccnt = ccnt + CW'(cy[i]);
  end
endmodule

// File: rtl/tap_array_mult.sv
module tap_array_mult #(
  parameter int DW = 4,
  parameter int CW = 8,
  localparam int PW = 2 * DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [PW-1:0] prod,
  output logic [CW-1:0] ccnt
);
  logic [PW-1:0] part      [DW];
  logic [PW-1:0] run       [DW+1];
  logic [CW-1:0] stage_cnt [DW];

  assign run[0] = '0;

  for (genvar g = 0; g < DW; g++) begin : g_row
    assign part[g] = b[g] ? (PW'(a) << g) : '0;
    tap_ripple_add #(.W(PW), .CW(CW)) u_add (
      .a   (run[g]),
      .b   (part[g]),
      .sum (run[g+1]),
      .ccnt(stage_cnt[g])
    );
  end

  assign prod = run[DW];

  always_comb begin
    ccnt = '0;
    for (int i = 0; i < DW; i++) ccnt = ccnt + stage_cnt[i];
  end
endmodule

// File: rtl/berger_mac_tap.sv
module berger_mac_tap
  import tap_pkg::*;
#(
  parameter int DW   = 4,
  parameter int TAPS = 8,
  localparam int AW  = acc_w(DW, TAPS),
  localparam int KD  = cnt_w(DW),
  localparam int KA  = cnt_w(AW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] coef,
  input  logic [KD-1:0] coef_cnt,
  input  logic [DW-1:0] smp,
  input  logic [KD-1:0] smp_cnt,
  input  logic [AW-1:0] acc_in,
  input  logic [KA-1:0] acc_in_cnt,
  output logic [AW-1:0] acc_out,
  output logic [KA-1:0] acc_out_cnt,
  output logic          chk_err
);
  localparam int CW = sum_w(DW, AW);

  logic [2*DW-1:0] prod;
  logic [CW-1:0]   mult_cc;
  logic [AW-1:0]   acc_next;
  logic [CW-1:0]   add_cc;
  logic [CW-1:0]   ones_next;
  logic [CW-1:0]   lhs, rhs, pred;

  tap_array_mult #(.DW(DW), .CW(CW)) u_mult (
    .a   (smp),
    .b   (coef),
    .prod(prod),
    .ccnt(mult_cc)
  );

  tap_ripple_add #(.W(AW), .CW(CW)) u_acc (
    .a   (acc_in),
    .b   (AW'(prod)),
    .sum (acc_next),
    .ccnt(add_cc)
  );

  tap_ones_count #(.W(AW), .CW(CW)) u_pop (
    .v  (acc_next),
    .cnt(ones_next)
  );

  // merged balance: counts in on the left, counts out plus carries on the right
  always_comb begin
    lhs  = CW'(coef_cnt) * CW'(smp_cnt) + CW'(acc_in_cnt);
    rhs  = ones_next + add_cc + mult_cc;
    pred = lhs - add_cc - mult_cc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out     <= '0;
      acc_out_cnt <= '0;
      chk_err     <= 1'b0;
    end else begin
      acc_out     <= acc_next;
      acc_out_cnt <= KA'(pred);
      chk_err     <= (lhs != rhs);
    end
  end
endmodule

// File: rtl/berger_mac_tap_chk.sv
module berger_mac_tap_chk
  import tap_pkg::*;
#(
  parameter int DW   = 4,
  parameter int TAPS = 8,
  localparam int AW  = acc_w(DW, TAPS),
  localparam int KD  = cnt_w(DW),
  localparam int KA  = cnt_w(AW)
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] coef,
  input logic [KD-1:0] coef_cnt,
  input logic [DW-1:0] smp,
  input logic [KD-1:0] smp_cnt,
  input logic [AW-1:0] acc_in,
  input logic [KA-1:0] acc_in_cnt,
  input logic [AW-1:0] acc_out,
  input logic [KA-1:0] acc_out_cnt,
  input logic          chk_err
);
  logic h_ok, x_ok, a_ok;
  assign h_ok = (32'(coef_cnt)   == $countones(coef));
  assign x_ok = (32'(smp_cnt)    == $countones(smp));
  assign a_ok = (32'(acc_in_cnt) == $countones(acc_in));

  assert_mac_sum_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc_out == AW'(AW'($past(acc_in)) + AW'($past(coef)) * AW'($past(smp))));

  assert_clean_no_err_R2: assert property (@(posedge clk) disable iff (rst)
    (h_ok && x_ok && a_ok) |=> !chk_err);

  assert_cnt_matches_R3: assert property (@(posedge clk) disable iff (rst)
    !chk_err |-> 32'(acc_out_cnt) == $countones(acc_out));

  assert_smp_fault_R4: assert property (@(posedge clk) disable iff (rst)
    (coef != '0 && h_ok && a_ok && !x_ok) |=> chk_err);

  assert_coef_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (smp != '0 && x_ok && a_ok && !h_ok) |=> chk_err);

  assert_acc_fault_R6: assert property (@(posedge clk) disable iff (rst)
    (h_ok && x_ok && !a_ok) |=> chk_err);
endmodule

bind berger_mac_tap berger_mac_tap_chk #(.DW(DW), .TAPS(TAPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .coef       (coef),
  .coef_cnt   (coef_cnt),
  .smp        (smp),
  .smp_cnt    (smp_cnt),
  .acc_in     (acc_in),
  .acc_in_cnt (acc_in_cnt),
  .acc_out    (acc_out),
  .acc_out_cnt(acc_out_cnt),
  .chk_err    (chk_err)
);

// File: tb/berger_mac_tap_test.sv
`timescale 1ns/1ps
module berger_mac_tap_test;
  localparam int DW   = 4;
  localparam int TAPS = 8;
  localparam int AW   = 2 * DW + $clog2(TAPS);
  localparam int KD   = $clog2(DW + 1);
  localparam int KA   = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] coef = '0;
  logic [KD-1:0] coef_cnt = '0;
  logic [DW-1:0] smp = '0;
  logic [KD-1:0] smp_cnt = '0;
  logic [AW-1:0] acc_in = '0;
  logic [KA-1:0] acc_in_cnt = '0;
  logic [AW-1:0] acc_out;
  logic [KA-1:0] acc_out_cnt;
  logic          chk_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  berger_mac_tap #(.DW(DW), .TAPS(TAPS)) uut (
    .clk(clk), .rst(rst),
    .coef(coef), .coef_cnt(coef_cnt),
    .smp(smp), .smp_cnt(smp_cnt),
    .acc_in(acc_in), .acc_in_cnt(acc_in_cnt),
    .acc_out(acc_out), .acc_out_cnt(acc_out_cnt),
    .chk_err(chk_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply one vector, wait for the register, compare on the falling edge
  task automatic run_vec(input int h, input int x, input int a,
                         input int hc, input int xc, input int ac,
                         input string err_tag, input string sum_tag);
    int exp_sum, exp_err;
    @(negedge clk);
    coef = DW'(h); smp = DW'(x); acc_in = AW'(a);
    coef_cnt = KD'(hc); smp_cnt = KD'(xc); acc_in_cnt = KA'(ac);
    @(negedge clk);
    exp_sum = (a + h * x) % (1 << AW);
    exp_err = ((hc * xc + ac) != ($countones(h) * $countones(x) + $countones(a))) ? 1 : 0;
    check({sum_tag, " sum"}, int'(acc_out), exp_sum);
    check({err_tag, " flag"}, int'(chk_err), exp_err);
    if (exp_err == 0)
      check("R3 count", int'(acc_out_cnt), $countones(exp_sum));
  endtask

  initial begin
    int avals [8] = '{0, 1, 2047, 1365, 682, 1792, 255, 1024};
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 reset sum", int'(acc_out), 0);
    check("R8 reset cnt", int'(acc_out_cnt), 0);
    check("R8 reset flag", int'(chk_err), 0);
    rst = 1'b0;

    // R1 R2 R3: exhaustive fault-free sweep
    for (int ai = 0; ai < 8; ai++)
      for (int h = 0; h < (1 << DW); h++)
        for (int x = 0; x < (1 << DW); x++)
          run_vec(h, x, avals[ai], $countones(h), $countones(x),
                  $countones(avals[ai]), "R2", "R1");

    // R7: wrap of the accumulator with clean counts
    run_vec(15, 15, 2047, 4, 4, 11, "R7", "R7");
    run_vec(1, 1, 2047, 1, 1, 11, "R7", "R7");

    // R4: sample count one too high
    for (int h = 0; h < (1 << DW); h++)
      for (int x = 0; x < (1 << DW); x++)
        run_vec(h, x, 1365, $countones(h), $countones(x) + 1, 6, "R4", "R1");

    // R5: coefficient count one too high
    for (int h = 0; h < (1 << DW); h++)
      for (int x = 0; x < (1 << DW); x++)
        run_vec(h, x, 682, $countones(h) + 1, $countones(x), 5, "R5", "R1");

    // R6: partial-sum count off in either direction
    for (int ai = 0; ai < 8; ai++) begin
      run_vec(0, 0, avals[ai], 0, 0, $countones(avals[ai]) + 1, "R6", "R1");
      run_vec(9, 6, avals[ai], 2, 2, $countones(avals[ai]) + 2, "R6", "R1");
    end
    run_vec(7, 3, 2047, 3, 2, 10, "R6", "R1");

    // R8: reset in the middle of a run with faulty counts applied
    @(negedge clk);
    coef = 4'hF; smp = 4'hF; acc_in = 11'h3FF;
    coef_cnt = 3'd1; smp_cnt = 3'd2; acc_in_cnt = 4'd3;
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid sum", int'(acc_out), 0);
    check("R8 mid cnt", int'(acc_out_cnt), 0);
    check("R8 mid flag", int'(chk_err), 0);
    rst = 1'b0;
    run_vec(5, 10, 100, 2, 2, $countones(100), "R2", "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule